// File: doc/BRIEF.md
# Read-Key Mode Register Loader

This block lives inside a pseudo-static memory model and lets software change the device's mode register without any dedicated write command. It watches the ordinary asynchronous read traffic on the chip-select, output-enable, write-enable and address pins. It samples these pins on the system clock. When it sees a fixed unlock pattern of five plain reads, it takes the address of the fifth read as the new register value.

The unlock pattern has four key reads followed by one data read. The first three reads use the all-ones address 0x3FFFFF. The fourth read uses 0x3FFEFF. The fifth read carries the value to load. Chip select must go high between reads, and each return of chip select to high closes one cycle of the pattern. Any out-of-pattern traffic throws the sequence back to its start. The loaded fields are decoded onto dedicated outputs. A one-clock pulse marks each completed update.

Top module: `mode_key_loader`

## Requirements
- R1: After reset the outputs are burst_code = 3'b111, refresh_en = 0, refresh_top = 0, refresh_size = 2'b00 and update_pulse = 0.
- R2: A cycle is one interval of sampled cs_n low. It ends at the first clock edge that samples cs_n high. It counts as a read only if oe_n was sampled low and we_n was never sampled low during it. A cycle with oe_n held high throughout is not a read.
- R3: The sequence is three reads at address 0x3FFFFF, then one read at 0x3FFEFF, then a fifth read whose address is loaded.
- R4: A read at any address other than the one expected for its position sends the sequence back to its first position. This holds even when that address is a valid key for the first position, so it does not itself start a new sequence.
- R5: A non-read cycle (any cycle with we_n sampled low, or with oe_n never sampled low) at any position sends the sequence back to its first position. When such a cycle comes in the fifth position, nothing is loaded.
- R6: The new field values and update_pulse appear on the clock edge that samples cs_n high at the end of the fifth read. update_pulse is high for exactly one clock.
- R7: If address bit 12 of the fifth read is 1, nothing is loaded, no pulse is issued and the sequence restarts.
- R8: On a load, refresh_en takes A4, refresh_top takes A3 (0 = bottom, 1 = top) and refresh_size takes A1:A0 (00 full, 01 half, 10 quarter, 11 three quarters).
- R9: On a load, burst_code takes A7:A5 when that value is 010, 011, 100 or 111. The reserved codes 000, 001, 101 and 110 load the default 111 instead. The other fields still load normally.
- R10: The register fields change only on a clock where update_pulse is driven high.
- R11: After a load the sequence is back at its first position, so a new five-read sequence can follow at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 22 | Address bus |
| burst_code | output | 3 | Decoded burst field |
| refresh_en | output | 1 | Partial refresh enable |
| refresh_top | output | 1 | Partial refresh array half select |
| refresh_size | output | 2 | Partial refresh size code |
| update_pulse | output | 1 | One-clock marker of a completed load |

## Verification
The bench replays the key sequence with breaks at every position. It uses wrong addresses, a key address read in the wrong slot, write cycles and cycles with no output enable. A design that let a misplaced 0x3FFFFF read count as a fresh first key would load on a shortened sequence. A design that did not clear on writes would load after a write interrupts the keys. It also sends reserved burst codes alongside live refresh bits. A design that dropped the whole word, or kept the raw code, would show the wrong field. A fifth read with bit 12 set must leave the register untouched. Every clock is compared against a behavioural model, so a pulse that comes one cycle late or lasts two clocks is caught.

// File: rtl/mkl_pkg.sv
package mkl_pkg;

    typedef struct packed {
        logic [2:0] burst;
        logic       ref_en;
        logic       ref_top;
        logic [1:0] ref_size;
    } mode_t;

    localparam logic [2:0] BURST_DEFAULT = 3'b111;

    localparam mode_t MODE_RESET = '{
        burst:    BURST_DEFAULT,
        ref_en:   1'b0,
        ref_top:  1'b0,
        ref_size: 2'b00
    };

    function automatic logic burst_is_reserved(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) ||
               (code == 3'b101) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/mkl_cycle_tracker.sv
module mkl_cycle_tracker #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_end,
    output logic              cyc_read,
    output logic [ADDR_W-1:0] cyc_addr
);

    typedef struct packed {
        logic              active;
        logic              saw_oe;
        logic              saw_we;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cs_n) begin
            st_d.active = 1'b1;
            st_d.addr   = addr;
            if (!st_q.active) begin
                st_d.saw_oe = !oe_n;
                st_d.saw_we = !we_n;
            end else begin
                st_d.saw_oe = st_q.saw_oe | !oe_n;
                st_d.saw_we = st_q.saw_we | !we_n;
            end
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_end  = st_q.active && cs_n;
    assign cyc_read = st_q.saw_oe && !st_q.saw_we;
    assign cyc_addr = st_q.addr;

endmodule

// File: rtl/mkl_key_seq.sv
module mkl_key_seq #(
    parameter int                ADDR_W   = 22,
    parameter int                N_LEAD   = 3,
    parameter logic [ADDR_W-1:0] KEY_LEAD = 22'h3FFFFF,
    parameter logic [ADDR_W-1:0] KEY_LAST = 22'h3FFEFF,
    parameter int                RSV_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_end,
    input  logic              cyc_read,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              load_o
);

    localparam int             LAST_POS = N_LEAD + 1;
    localparam int             SW       = $clog2(LAST_POS + 1);
    localparam logic [SW-1:0]  POS_LAST = SW'(N_LEAD);
    localparam logic [SW-1:0]  POS_DATA = SW'(LAST_POS);

    typedef struct packed {
        logic [SW-1:0] pos;
    } seq_t;

    seq_t st_d, st_q;
    logic key_ok;

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        key_ok = (st_q.pos < POS_LAST) ? (cyc_addr == KEY_LEAD)
                                        : (cyc_addr == KEY_LAST);
        if (cyc_end) begin
            if (!cyc_read) begin
                st_d.pos = '0;
            end else if (st_q.pos == POS_DATA) begin
                load_o   = !cyc_addr[RSV_BIT];
                st_d.pos = '0;
            end else if (key_ok) begin
                st_d.pos = st_q.pos + 1'b1;
            end else begin
                st_d.pos = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_DATA); // R3

    AST_NONREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !cyc_read) |=> (st_q.pos == '0)); // R5

    AST_RESTART_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (st_q.pos == '0)); // R11

endmodule

// File: rtl/mkl_field_decode.sv
module mkl_field_decode
    import mkl_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] word,
    output mode_t             mode
);

    always_comb begin
        mode.burst    = burst_is_reserved(word[7:5]) ? BURST_DEFAULT : word[7:5];
        mode.ref_en   = word[4];
        mode.ref_top  = word[3];
        mode.ref_size = word[1:0];
    end

endmodule

// File: rtl/mode_key_loader.sv
module mode_key_loader
    import mkl_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        burst_code,
    output logic              refresh_en,
    output logic              refresh_top,
    output logic [1:0]        refresh_size,
    output logic              update_pulse
);

    typedef struct packed {
        mode_t mode;
        logic  pulse;
    } top_t;

    logic              cyc_end;
    logic              cyc_read;
    logic [ADDR_W-1:0] cyc_addr;
    logic              load;
    mode_t             dec_mode;
    top_t              st_d, st_q;

    mkl_cycle_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .cyc_end  (cyc_end),
        .cyc_read (cyc_read),
        .cyc_addr (cyc_addr)
    );

    mkl_key_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_end  (cyc_end),
        .cyc_read (cyc_read),
        .cyc_addr (cyc_addr),
        .load_o   (load)
    );

    mkl_field_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word (cyc_addr),
        .mode (dec_mode)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = load;
        if (load) st_d.mode = dec_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_RESET;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign burst_code   = st_q.mode.burst;
    assign refresh_en   = st_q.mode.ref_en;
    assign refresh_top  = st_q.mode.ref_top;
    assign refresh_size = st_q.mode.ref_size;
    assign update_pulse = st_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse); // R6

    AST_PULSE_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |-> $past(cs_n)); // R6

    AST_REG_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> update_pulse); // R10

    AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_is_reserved(burst_code)); // R9

endmodule

// File: tb/mode_key_loader_tb.sv
`timescale 1ns/1ps
module mode_key_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [21:0] addr = '0;
    logic [2:0]  burst_code;
    logic        refresh_en;
    logic        refresh_top;
    logic [1:0]  refresh_size;
    logic        update_pulse;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int       m_pos = 0;
    logic [2:0] e_burst = 3'b111;
    logic       e_en = 1'b0;
    logic       e_top = 1'b0;
    logic [1:0] e_size = 2'b00;
    logic       e_pulse = 1'b0;
    string      cur_req = "R1";
    logic       live = 1'b0;

    always #2.5 clk = ~clk;

    mode_key_loader u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .addr         (addr),
        .burst_code   (burst_code),
        .refresh_en   (refresh_en),
        .refresh_top  (refresh_top),
        .refresh_size (refresh_size),
        .update_pulse (update_pulse)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R10 and R6: every clock the outputs must match the model
    always @(negedge clk) begin
        if (live) begin
            check(cur_req, "burst_code", burst_code, e_burst);
            check(cur_req, "refresh_en", refresh_en, e_en);
            check(cur_req, "refresh_top", refresh_top, e_top);
            check(cur_req, "refresh_size", refresh_size, e_size);
            check(cur_req, "update_pulse", update_pulse, e_pulse);
        end
    end

    function automatic void model_end(input logic [21:0] a, input bit rd, output bit ld);
        ld = 0;
        if (!rd) m_pos = 0;
        else if (m_pos == 4) begin
            m_pos = 0;
            if (a[12] == 1'b0) ld = 1;
        end else if ((m_pos < 3 && a == 22'h3FFFFF) || (m_pos == 3 && a == 22'h3FFEFF))
            m_pos = m_pos + 1;
        else m_pos = 0;
    endfunction

    // one bus cycle: cs low for two clocks, then high
    task automatic bus(input logic [21:0] a, input bit oe_on, input bit we_on);
        bit rd, ld;
        @(negedge clk);
        cs_n = 1'b0; addr = a; oe_n = !oe_on; we_n = !we_on;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0;
        rd = oe_on && !we_on;
        model_end(a, rd, ld);
        @(posedge clk); #1;
        if (ld) begin
            case (a[7:5])
                3'b000, 3'b001, 3'b101, 3'b110: e_burst = 3'b111;
                default: e_burst = a[7:5];
            endcase
            e_en = a[4]; e_top = a[3]; e_size = a[1:0];
        end
        e_pulse = ld;
        @(posedge clk); #1;
        e_pulse = 1'b0;
    endtask

    task automatic rd(input logic [21:0] a);
        bus(a, 1'b1, 1'b0);
    endtask

    task automatic keys();
        rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFEFF);
    endtask

    task automatic expect_mode(input string req, input int b, input int en, input int top, input int sz);
        @(negedge clk);
        check(req, "burst_code", burst_code, b);
        check(req, "refresh_en", refresh_en, en);
        check(req, "refresh_top", refresh_top, top);
        check(req, "refresh_size", refresh_size, sz);
    endtask

    task automatic run_all();
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset values
        expect_mode("R1", 3'b111, 0, 0, 0);
        check("R1", "update_pulse", update_pulse, 0);

        // R3 R8 R9: full sequence, legal burst 011, all refresh bits set
        cur_req = "R3";
        keys(); rd(22'h00007B);
        expect_mode("R8", 3'b011, 1, 1, 3);

        // R9 reserved burst 101 with live refresh fields
        cur_req = "R9";
        keys(); rd(22'h0000A2);
        expect_mode("R9", 3'b111, 0, 0, 2);
        keys(); rd(22'h000089);
        expect_mode("R9", 3'b100, 0, 1, 1);

        // R4 wrong address at position 3, then the rest of the pattern
        cur_req = "R4";
        rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFFFE); rd(22'h3FFEFF); rd(22'h000053);
        expect_mode("R4", 3'b100, 0, 1, 1);
        // R4 a key address read in the last-key slot is a mismatch, not a restart
        rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFFFF);
        rd(22'h3FFFFF); rd(22'h3FFFFF); rd(22'h3FFEFF); rd(22'h000053);
        expect_mode("R4", 3'b100, 0, 1, 1);

        // R5 write during keys, and write in the data slot
        cur_req = "R5";
        rd(22'h3FFFFF); bus(22'h3FFFFF, 1'b1, 1'b1); rd(22'h3FFFFF); rd(22'h3FFEFF); rd(22'h000053);
        expect_mode("R5", 3'b100, 0, 1, 1);
        keys(); bus(22'h000053, 1'b0, 1'b1);
        expect_mode("R5", 3'b100, 0, 1, 1);

        // R2 cycle without output enable is not a read
        cur_req = "R2";
        keys(); bus(22'h000053, 1'b0, 1'b0);
        expect_mode("R2", 3'b100, 0, 1, 1);
        keys(); rd(22'h000053);
        expect_mode("R2", 3'b010, 1, 0, 3);

        // R7 bit 12 set in data slot
        cur_req = "R7";
        keys(); rd(22'h00107B);
        expect_mode("R7", 3'b010, 1, 0, 3);

        // R11 back-to-back sequences, and R6 pulse count
        cur_req = "R11";
        pulses = 0;
        fork
            begin
                repeat (200) begin
                    @(negedge clk);
                    if (update_pulse) pulses++;
                end
            end
            begin
                keys(); rd(22'h000060);
                keys(); rd(22'h0000E8);
            end
        join
        check("R6", "pulse count", pulses, 2);
        expect_mode("R11", 3'b111, 0, 1, 0);
        live = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL R3 watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule